// File: doc/BRIEF.md
# Row-Sequential Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands into a 2N-bit product. It does not use one combinational array. It steps through an adder array one row at a time. Each row owns a fixed slot of clock beats. The first slot forms the AND plane of operand `a` with multiplier bit b0. Product bit 0 is taken straight from a0 AND b0.

Each later slot runs one adder row:
- The row's x inputs are the sums handed down by the row above.
- The row's y inputs are `a` ANDed with the next multiplier bit.
- The cell in the lowest position is a half adder. The other cells are full adders, and the carry ripples along the row.
- The lowest sum of each row becomes one product bit.
- The last row supplies all the remaining upper bits.

A one-cycle `start` pulse launches an operation. `busy` stays high for N slots of BEATS clocks each. `done` pulses once, in the same cycle the product appears. With the defaults (N=4, BEATS=4) there are three adder rows of four cells, and an operation spans four slots, which is sixteen clocks.

Top module: `rowseq_mult`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is 1 from the next cycle onward.
- R3: After an accepted start, `product` equals the unsigned product of the `op_a` and `op_b` values sampled with that start, for every operand pair. With N=4 this includes 15×15=225.
- R4: `done` is 1 exactly N×BEATS clock edges after the edge that accepted the start (16 with defaults). `busy` is 1 for each of those cycles.
- R5: `done` is high for exactly one cycle, and `busy` is 0 while `done` is 1.
- R6: A `start` sampled while `busy` is 1 is ignored. It does not change the running result or its timing, and it causes no further `done`.
- R7: `product` changes only in the cycle where `done` is 1. It holds its value until the next operation completes.
- R8: Changes on `op_a` and `op_b` after the start is accepted do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse (frame sync) |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier |
| product | output | 2N | Registered product |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things are hard to bring about from the ports: a launch that overlaps a running operation, and operand inputs that move while the rows are still being evaluated. The stimulus pulses `start` with different operands in the middle of a run. In a separate run it scrambles `op_a` and `op_b` every cycle until completion. In both cases the completion must show the original product at the original time, and no extra `done` may follow. A full sweep of all 256 operand pairs, launched back to back, exercises every carry path through the rows. The sweep also relaunches in the very cycle each `done` appears.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rsm_state_e;
endpackage

// File: rtl/rsm_pacer.sv
// Beat and slot counters: one slot per adder row, BEATS clocks each.
module rsm_pacer #(
  parameter int N     = 4,
  parameter int BEATS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  launch,
  input  logic                                  run,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0]  slot_idx,
  output logic                                  slot_tick,
  output logic                                  final_tick
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] BEAT_MAX = BW'(BEATS - 1);
  localparam logic [SW-1:0] SLOT_MAX = SW'(N - 1);

  logic [BW-1:0] beat_q, beat_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          beat_last;

  always_comb begin
    beat_last = (beat_q == BEAT_MAX);
    beat_d    = beat_q;
    slot_d    = slot_q;
    if (launch) begin
      beat_d = '0;
      slot_d = '0;
    end else if (run) begin
      beat_d = beat_last ? '0 : beat_q + 1'b1;
      if (beat_last) slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      slot_q <= '0;
    end else if (launch || run) begin
      beat_q <= beat_d;
      slot_q <= slot_d;
    end
  end

  assign slot_idx   = slot_q;
  assign slot_tick  = run && beat_last;
  assign final_tick = slot_tick && (slot_q == SLOT_MAX);

  p_beat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q <= BEAT_MAX);
  p_slot_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (slot_q <= SLOT_MAX));
  p_launch_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (beat_q == '0 && slot_q == '0));
endmodule

// File: rtl/rsm_ppgen.sv
// AND plane for one multiplier bit.
module rsm_ppgen #(
  parameter int N = 4
) (
  input  logic [N-1:0] a,
  input  logic         mbit,
  output logic [N-1:0] pp
);
  for (genvar i = 0; i < N; i++) begin : g_and
    assign pp[i] = a[i] & mbit;
  end
endmodule

// File: rtl/rsm_adder_row.sv
// One adder row: half adder in the lowest cell, full adders above it,
// carry rippling upward along the row.
module rsm_adder_row #(
  parameter int N = 4
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] s,
  output logic         cout
);
  always_comb begin
    logic c;
    c = 1'b0;
    s = '0;
    for (int i = 0; i < N; i++) begin
      if (i == 0) begin
        s[i] = x[i] ^ y[i];
        c    = x[i] & y[i];
      end else begin
        s[i] = x[i] ^ y[i] ^ c;
        c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
      end
    end
    cout = c;
  end
endmodule

// File: rtl/rowseq_mult.sv
module rowseq_mult
  import rsm_pkg::*;
#(
  parameter int N     = 4,
  parameter int BEATS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] product,
  output logic           busy,
  output logic           done
);
  localparam int PW = 2 * N;
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  rsm_state_e    state_q, state_d;
  logic [N-1:0]  a_q, b_q;
  logic [N-1:0]  acc_q, acc_d;
  logic [N-1:0]  low_q, low_d;
  logic [PW-1:0] prod_q, prod_d;
  logic          done_q, done_d;

  logic          launch, run;
  logic [SW-1:0] slot_idx;
  logic          slot_tick, final_tick;
  logic [N-1:0]  pp, row_s;
  logic          row_cout;

  assign run    = (state_q == ST_RUN);
  assign launch = start && (state_q == ST_IDLE);

  rsm_pacer #(.N(N), .BEATS(BEATS)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .run        (run),
    .slot_idx   (slot_idx),
    .slot_tick  (slot_tick),
    .final_tick (final_tick)
  );

  rsm_ppgen #(.N(N)) u_ppgen (
    .a    (a_q),
    .mbit (b_q[slot_idx]),
    .pp   (pp)
  );

  rsm_adder_row #(.N(N)) u_row (
    .x    (acc_q),
    .y    (pp),
    .s    (row_s),
    .cout (row_cout)
  );

  always_comb begin
    state_d = state_q;
    if (launch)          state_d = ST_RUN;
    else if (final_tick) state_d = ST_IDLE;

    acc_d = acc_q;
    low_d = low_q;
    if (slot_tick) begin
      if (slot_idx == '0) begin
        acc_d    = {1'b0, pp[N-1:1]};
        low_d[0] = pp[0];
      end else begin
        acc_d           = {row_cout, row_s[N-1:1]};
        low_d[slot_idx] = row_s[0];
      end
    end

    prod_d = {row_cout, row_s[N-1:1], row_s[0], low_q[N-2:0]};
    done_d = final_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      low_q   <= '0;
      prod_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (launch) begin
        a_q <= op_a;
        b_q <= op_b;
      end
      if (slot_tick) begin
        acc_q <= acc_d;
        low_q <= low_d;
      end
      if (final_tick) prod_q <= prod_d;
    end
  end

  assign product = prod_q;
  assign busy    = run;
  assign done    = done_q;

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_done_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_prod_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
  p_ops_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(a_q) && $stable(b_q)));
endmodule

// File: tb/rowseq_mult_bench.sv
`timescale 1ns/1ps
module rowseq_mult_bench;
  localparam int N     = 4;
  localparam int BEATS = 4;
  localparam int PW    = 2 * N;
  localparam int LAT   = N * BEATS;

  typedef struct {
    logic [PW-1:0] prod;
    int            due;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [N-1:0]  op_a, op_b;
  logic [PW-1:0] product;
  logic          busy, done;

  int   cyc = 0;
  int   checks = 0;
  int   errs = 0;
  bit   finished = 0;
  bit   prev_done = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rowseq_mult #(.N(N), .BEATS(BEATS)) u_rowseq_mult (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product),
    .busy    (busy),
    .done    (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  // Driver: waits for idle, launches, pushes the expected item.
  task automatic launch(input int ai, input int bi);
    exp_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    op_a  = N'(ai);
    op_b  = N'(bi);
    start = 1'b1;
    it.prod = PW'(ai * bi);
    it.due  = cyc + 1 + LAT;
    exp_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops and compares on every completion.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (done) begin
        check(busy == 1'b0, "R5 busy low with done", int'(busy), 0);
        check(!prev_done, "R5 done single cycle", int'(prev_done), 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          exp_t it;
          it = exp_q.pop_front();
          check(product == it.prod, "R3 product", int'(product), int'(it.prod));
          check(cyc == it.due, "R4 done latency", cyc, it.due);
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL R4 watchdog actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    op_a  = '0;
    op_b  = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(product == '0, "R1 product in reset", int'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after release",
          int'({busy, done}), 0);
    check(product == '0, "R1 product after release", int'(product), 0);

    // R3 / R4: full operand sweep, back to back.
    for (int i = 0; i < (1 << N); i++)
      for (int j = 0; j < (1 << N); j++)
        launch(i, j);
    drain();

    // R3: all-ones corner.
    launch(15, 15);
    drain();
    check(product == 8'd225, "R3 all-ones 15x15", int'(product), 225);

    // R6: start while busy is ignored.
    launch(9, 13);
    repeat (5) @(negedge clk);
    op_a  = 4'd2;
    op_b  = 4'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 still busy after ignored start", int'(busy), 1);
    drain();
    repeat (LAT + 4) @(negedge clk);
    check(product == 8'd117, "R6 result unchanged", int'(product), 117);
    check(busy == 1'b0, "R6 no second run", int'(busy), 0);

    // R8: operand inputs scrambled after the start is accepted.
    launch(11, 7);
    for (int k = 0; k < LAT + 2; k++) begin
      op_a = N'(k * 5 + 3);
      op_b = N'(k * 3 + 1);
      @(negedge clk);
    end
    drain();
    check(product == 8'd77, "R8 operands frozen", int'(product), 77);

    // R7: product holds while idle and inputs move.
    for (int k = 0; k < 10; k++) begin
      op_a = N'(k);
      op_b = N'(15 - k);
      @(negedge clk);
    end
    check(product == 8'd77, "R7 product held", int'(product), 77);
    check(done == 1'b0, "R7 no spurious done", int'(done), 0);
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule